// File: doc/BRIEF.md
# Shared Reorder Buffer Capacity Partition Controller

This block performs capacity bookkeeping for a reorder buffer that up to `NT` hardware threads share. It does not hold any entries and it does not decide retirement. From a sharing-policy select, a configured thread count, an active-thread mask and an occupancy count per thread, it keeps one registered entry limit per thread. From those limits it derives a free count per thread, a free count for the whole buffer, and a stall signal per thread. The allocator upstream reads these to decide admission.

Three policies are available. Under the greedy policy every configured thread may fill the whole buffer. Under the even-split policy the capacity is divided equally among the threads. Under the cap policy every configured thread is bounded by a programmable value. The limits are recomputed one clock after any change to the policy, the configured count, the active mask or the cap value. They are therefore derived from the current number of active threads, not fixed at reset. An illegal policy code raises an error flag and leaves the limits as they were. A recomputation with no active configured thread also leaves the limits untouched.

Top module: `rob_cap_ctrl`

## Requirements
- R1: With policy code 0 (greedy), every thread whose index is below `cfg_threads_i` receives a limit equal to `CAP`.
- R2: With policy code 1 (even split), each active configured thread receives `CAP / n`, where n is the number of set bits of `active_i` at indices below `cfg_threads_i`. Each inactive configured thread receives `CAP / cfg_threads_i`. Both divisions are integer divisions.
- R3: With policy code 2 (cap), every configured thread receives `min(threshold_i, CAP)`. When exactly one configured thread is active, that thread receives `CAP`.
- R4: Any thread whose index is at or above `cfg_threads_i` receives a limit of 0.
- R5: After reset, all limits are 0, `policy_err_o` is 0, and every bit of `stall_o` is 1.
- R6: A change on `policy_i`, `cfg_threads_i`, `active_i` or `threshold_i` (and the first clock after reset) appears on `limit_o` exactly one rising edge later. The limits do not change in any cycle without such a change.
- R7: Policy code 3 is illegal. It sets `policy_err_o` after the next edge and holds every limit.
- R8: A recomputation in which no configured thread is active holds every limit, so no division by zero takes place.
- R9: `free_o` for a thread is its limit minus its `occ_i` field, saturated at 0.
- R10: `global_free_o` is `CAP` minus the sum of all `occ_i` fields, saturated at 0.
- R11: `stall_o[t]` is 1 exactly when thread t's free count is 0 or the global free count is 0.

Packed fields: thread t occupies bits `[t*CW +: CW]` of `occ_i`, `limit_o` and `free_o`, where `CW = $clog2(CAP+1)`. Bit t of `active_i` and of `stall_o` refers to thread t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | Sharing policy: 0 greedy, 1 even split, 2 cap, 3 illegal |
| cfg_threads_i | input | TW | Number of configured threads (0..NT) |
| active_i | input | NT | Active-thread mask |
| threshold_i | input | CW | Per-thread cap value for policy 2 |
| occ_i | input | NT*CW | Occupancy count per thread |
| limit_o | output | NT*CW | Registered entry limit per thread |
| free_o | output | NT*CW | Free entries per thread |
| global_free_o | output | CW | Free entries in the whole buffer |
| stall_o | output | NT | Admission stall per thread |
| policy_err_o | output | 1 | Illegal policy code seen |

## Verification
A wrong limit register shows up directly on `limit_o` one edge after the input change that should have produced it. Through the combinational free and stall paths, it also corrupts `free_o` and `stall_o` in that same cycle. The snapshot registers used for change detection are checked indirectly. A missed change leaves `limit_o` stale one edge later. A spurious change does not alter the limits under a fixed configuration, so the held-limit cases are instead placed after states whose recomputation would visibly differ. Saturation faults appear only when an occupancy exceeds its limit or the buffer is overcommitted, and the bench drives both.

// File: rtl/rob_cap_pkg.sv
package rob_cap_pkg;
  typedef enum logic [1:0] {
    POL_GREEDY = 2'd0,
    POL_SPLIT  = 2'd1,
    POL_CAP    = 2'd2,
    POL_BAD    = 2'd3
  } pol_e;
endpackage

// File: rtl/rob_limit_calc.sv
module rob_limit_calc
  import rob_cap_pkg::*;
#(
  parameter int NT  = 4,
  parameter int CAP = 64,
  localparam int CW = $clog2(CAP + 1),
  localparam int TW = $clog2(NT + 1)
) (
  input  logic [1:0]             policy_i,
  input  logic [TW-1:0]          cfg_i,
  input  logic [NT-1:0]          active_i,
  input  logic [CW-1:0]          thr_i,
  output logic [NT-1:0][CW-1:0]  lim_o,
  output logic [TW-1:0]          act_cnt_o
);

  localparam logic [CW-1:0] CAP_W = CW'(CAP);

  // constant quotients only; no divider is built
  function automatic logic [CW-1:0] share(input logic [TW-1:0] n);
    logic [CW-1:0] res;
    res = '0;
    for (int k = 1; k <= NT; k++) begin
      if (n == TW'(k)) res = CW'(CAP / k);
    end
    return res;
  endfunction

  logic [NT-1:0] cfg_m;
  logic [NT-1:0] act_m;
  logic [CW-1:0] thr_c;
  logic [CW-1:0] base;

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      cfg_m[t] = (TW'(t) < cfg_i);
    end
    act_m = cfg_m & active_i;
    act_cnt_o = '0;
    for (int t = 0; t < NT; t++) begin
      act_cnt_o = act_cnt_o + TW'(act_m[t]);
    end
  end

  assign thr_c = (thr_i > CAP_W) ? CAP_W : thr_i;

  always_comb begin
    unique case (pol_e'(policy_i))
      POL_GREEDY: base = CAP_W;
      POL_SPLIT:  base = share(cfg_i);
      POL_CAP:    base = thr_c;
      default:    base = '0;
    endcase
  end

  // greedy needs no active-set adjustment, so the single-thread skip is implicit
  always_comb begin
    for (int t = 0; t < NT; t++) begin
      lim_o[t] = cfg_m[t] ? base : '0;
      if (act_m[t]) begin
        if (pol_e'(policy_i) == POL_SPLIT) begin
          lim_o[t] = share(act_cnt_o);
        end else if (pol_e'(policy_i) == POL_CAP && act_cnt_o == TW'(1)) begin
          lim_o[t] = CAP_W;
        end
      end
    end
  end

endmodule

// File: rtl/rob_free_slot.sv
module rob_free_slot #(
  parameter int CAP = 64,
  localparam int CW = $clog2(CAP + 1)
) (
  input  logic [CW-1:0] lim_i,
  input  logic [CW-1:0] occ_i,
  output logic [CW-1:0] free_o
);
  assign free_o = (occ_i >= lim_i) ? '0 : (lim_i - occ_i);
endmodule

// File: rtl/rob_global_free.sv
module rob_global_free #(
  parameter int NT  = 4,
  parameter int CAP = 64,
  localparam int CW = $clog2(CAP + 1),
  localparam int SW = $clog2(NT * CAP + 1)
) (
  input  logic [NT-1:0][CW-1:0] occ_i,
  output logic [CW-1:0]         gfree_o
);
  logic [SW-1:0] sum;

  always_comb begin
    sum = '0;
    for (int t = 0; t < NT; t++) begin
      sum = sum + SW'(occ_i[t]);
    end
  end

  assign gfree_o = (sum >= SW'(CAP)) ? '0 : CW'(SW'(CAP) - sum);
endmodule

// File: rtl/rob_cap_ctrl.sv
module rob_cap_ctrl
  import rob_cap_pkg::*;
#(
  parameter int NT  = 4,
  parameter int CAP = 64,
  localparam int CW = $clog2(CAP + 1),
  localparam int TW = $clog2(NT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        policy_i,
  input  logic [TW-1:0]     cfg_threads_i,
  input  logic [NT-1:0]     active_i,
  input  logic [CW-1:0]     threshold_i,
  input  logic [NT*CW-1:0]  occ_i,
  output logic [NT*CW-1:0]  limit_o,
  output logic [NT*CW-1:0]  free_o,
  output logic [CW-1:0]     global_free_o,
  output logic [NT-1:0]     stall_o,
  output logic              policy_err_o
);

  logic [NT-1:0][CW-1:0] nxt_lim, lim_q, occ_v, free_v;
  logic [TW-1:0]         act_cnt;
  logic [1:0]            pol_q;
  logic [TW-1:0]         cfg_q;
  logic [NT-1:0]         mask_q;
  logic [CW-1:0]         thr_q;
  logic                  first_q, err_q;
  logic                  chg, legal, load;

  assign occ_v = occ_i;

  rob_limit_calc #(.NT(NT), .CAP(CAP)) u_calc (
    .policy_i (policy_i),
    .cfg_i    (cfg_threads_i),
    .active_i (active_i),
    .thr_i    (threshold_i),
    .lim_o    (nxt_lim),
    .act_cnt_o(act_cnt)
  );

  assign chg   = first_q | (policy_i != pol_q) | (cfg_threads_i != cfg_q) |
                 (active_i != mask_q) | (threshold_i != thr_q);
  assign legal = (pol_e'(policy_i) != POL_BAD);
  assign load  = chg & legal & (act_cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      pol_q   <= '0;
      cfg_q   <= '0;
      mask_q  <= '0;
      thr_q   <= '0;
      err_q   <= 1'b0;
      lim_q   <= '0;
    end else begin
      first_q <= 1'b0;
      pol_q   <= policy_i;
      cfg_q   <= cfg_threads_i;
      mask_q  <= active_i;
      thr_q   <= threshold_i;
      err_q   <= ~legal;
      if (load) lim_q <= nxt_lim;
    end
  end

  rob_global_free #(.NT(NT), .CAP(CAP)) u_gfree (
    .occ_i  (occ_v),
    .gfree_o(global_free_o)
  );

  for (genvar t = 0; t < NT; t++) begin : g_slot
    rob_free_slot #(.CAP(CAP)) u_free (
      .lim_i (lim_q[t]),
      .occ_i (occ_v[t]),
      .free_o(free_v[t])
    );
    assign stall_o[t] = (free_v[t] == '0) | (global_free_o == '0);

    p_unconf_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load && (TW'(t) >= cfg_threads_i)) |=> (lim_q[t] == '0));
    p_lim_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lim_q[t] <= CW'(CAP));
    p_free_le_lim_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      free_v[t] <= lim_q[t]);
  end

  assign limit_o      = lim_q;
  assign free_o       = free_v;
  assign policy_err_o = err_q;

  p_bad_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg && !legal) |=> $stable(lim_q));
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg && act_cnt == '0) |=> $stable(lim_q));
  p_quiet_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg |=> $stable(lim_q));
  p_full_stall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (global_free_o == '0) |-> (&stall_o));

endmodule

// File: tb/tb_rob_cap_ctrl.sv
module tb_rob_cap_ctrl;
  localparam int NT = 4;
  localparam int CAP = 64;
  localparam int CW = 7;
  localparam int TW = 3;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] policy;
  logic [TW-1:0] cfg;
  logic [NT-1:0] active;
  logic [CW-1:0] thr;
  logic [NT*CW-1:0] occ, limit, free;
  logic [CW-1:0] gfree;
  logic [NT-1:0] stall;
  logic perr;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rob_cap_ctrl #(.NT(NT), .CAP(CAP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .cfg_threads_i(cfg),
    .active_i(active), .threshold_i(thr), .occ_i(occ), .limit_o(limit),
    .free_o(free), .global_free_o(gfree), .stall_o(stall), .policy_err_o(perr)
  );

  typedef struct packed {
    logic [1:0] pol; logic [2:0] cf; logic [3:0] msk; logic [6:0] th;
    logic [6:0] e0; logic [6:0] e1; logic [6:0] e2; logic [6:0] e3; logic er;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'd0, 3'd4, 4'hF, 7'd10,  7'd64, 7'd64, 7'd64, 7'd64, 1'b0}, // R1
    '{2'd1, 3'd4, 4'hF, 7'd10,  7'd16, 7'd16, 7'd16, 7'd16, 1'b0}, // R2
    '{2'd1, 3'd4, 4'h3, 7'd10,  7'd32, 7'd32, 7'd16, 7'd16, 1'b0}, // R2
    '{2'd1, 3'd3, 4'h7, 7'd10,  7'd21, 7'd21, 7'd21, 7'd0,  1'b0}, // R2 R4
    '{2'd1, 3'd3, 4'h1, 7'd10,  7'd64, 7'd21, 7'd21, 7'd0,  1'b0}, // R2
    '{2'd2, 3'd4, 4'hF, 7'd10,  7'd10, 7'd10, 7'd10, 7'd10, 1'b0}, // R3
    '{2'd2, 3'd4, 4'h4, 7'd10,  7'd10, 7'd10, 7'd64, 7'd10, 1'b0}, // R3
    '{2'd2, 3'd2, 4'h3, 7'd100, 7'd64, 7'd64, 7'd0,  7'd0,  1'b0}, // R3 clamp
    '{2'd0, 3'd1, 4'h1, 7'd10,  7'd64, 7'd0,  7'd0,  7'd0,  1'b0}, // R1 R4
    '{2'd1, 3'd2, 4'hC, 7'd10,  7'd64, 7'd0,  7'd0,  7'd0,  1'b0}, // R8
    '{2'd3, 3'd4, 4'hF, 7'd10,  7'd64, 7'd0,  7'd0,  7'd0,  1'b1}, // R7
    '{2'd1, 3'd4, 4'hF, 7'd10,  7'd16, 7'd16, 7'd16, 7'd16, 1'b0}  // R2
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lim_of(input int t);
    return int'(limit[t*CW +: CW]);
  endfunction

  function automatic int free_of(input int t);
    return int'(free[t*CW +: CW]);
  endfunction

  task automatic set_occ(input int o0, input int o1, input int o2, input int o3);
    occ = {CW'(o3), CW'(o2), CW'(o1), CW'(o0)};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    policy = 2'd0; cfg = 3'd4; active = 4'h0; thr = 7'd10; set_occ(0, 0, 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R5 reset state
    for (int t = 0; t < NT; t++) chk("R5 limit", lim_of(t), 0);
    chk("R5 err", int'(perr), 0);
    chk("R5 stall", int'(stall), 15);
    chk("R10 gfree idle", int'(gfree), 64);

    // table walk
    for (int i = 0; i < 12; i++) begin
      policy = VECS[i].pol; cfg = VECS[i].cf; active = VECS[i].msk; thr = VECS[i].th;
      @(negedge clk);
      chk($sformatf("R1-4/R7/R8 vec%0d t0", i), lim_of(0), int'(VECS[i].e0));
      chk($sformatf("vec%0d t1", i), lim_of(1), int'(VECS[i].e1));
      chk($sformatf("vec%0d t2", i), lim_of(2), int'(VECS[i].e2));
      chk($sformatf("vec%0d t3", i), lim_of(3), int'(VECS[i].e3));
      chk($sformatf("R7 err vec%0d", i), int'(perr), int'(VECS[i].er));
    end

    // R6 timing: limits must not move before the edge
    active = 4'h3;
    #1;
    chk("R6 before edge", lim_of(0), 16);
    @(negedge clk);
    chk("R6 after edge", lim_of(0), 32);
    @(negedge clk);
    chk("R6 quiet hold", lim_of(2), 16);

    // R9 R11 per-thread free/stall, limits 16 each
    active = 4'hF;
    @(negedge clk);
    set_occ(5, 16, 20, 0);
    #1;
    chk("R9 free t0", free_of(0), 11);
    chk("R9 free t1 full", free_of(1), 0);
    chk("R9 free t2 sat", free_of(2), 0);
    chk("R9 free t3", free_of(3), 16);
    chk("R10 gfree", int'(gfree), 23);
    chk("R11 stall", int'(stall), 6);

    set_occ(30, 30, 30, 30);
    #1;
    chk("R10 gfree sat", int'(gfree), 0);
    chk("R11 stall all", int'(stall), 15);

    // R11 global-only stall under greedy limits
    policy = 2'd0;
    @(negedge clk);
    set_occ(40, 24, 0, 0);
    #1;
    chk("R9 greedy free t2", free_of(2), 64);
    chk("R10 gfree zero", int'(gfree), 0);
    chk("R11 global stall", int'(stall), 15);
    set_occ(40, 0, 0, 0);
    #1;
    chk("R11 no stall", int'(stall), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule